// File: doc/BRIEF.md
# Timestamp Event Capture Unit

The unit keeps a free-running 32-bit time counter and copies its value into a timestamp register when a trigger occurs. The trigger is either an edge on an asynchronous external request pin, or a single-cycle internal pulse-per-second strobe. Software picks the source and the active edge, then polls a status word. The status word holds a valid flag, a missed-event flag, the source select and an 8-bit count of triggers.

After a capture, software reads the two timestamp words and then writes the status word back with the valid flag at zero. This re-arms the unit for the next capture. Further triggers that arrive while a capture is still valid set the missed-event flag. If the overwrite option is on, such a trigger also replaces the stored timestamp.

All access goes through a 16-bit register port. Writes are synchronous and reads are combinational. Word addresses:

| Address | Register | Access |
|---|---|---|
| 0 | configuration | read/write |
| 1 | tick period in picoseconds | read-only |
| 2 | status | read/write |
| 3 | timestamp low | read-only |
| 4 | timestamp high | read-only |
| 5 | live counter low | read-only |
| 6 | live counter high | read-only |

Top module: `evcap_unit`

## Requirements
- R1: After reset, the configuration register, the status word, the timestamp words and the live counter all read 0.
- R2: The live counter increases by exactly 1 every clock and wraps modulo 2^32. Its low word is at address 5 and its high word at address 6.
- R3: Configuration bits 2:0 read back as written, and its other bits read 0. Bit 0 is count-enable, bit 1 is overwrite and bit 2 is falling-edge select. Address 1 reads the tick period parameter, which defaults to 8000.
- R4: With falling-edge select at 0 and the external source selected, a rising edge on the external pin captures a timestamp. If the pin is driven in a cycle where the counter reads C, the timestamp is C+2, and the status word shows it 3 clocks after the pin changes. A falling edge captures nothing.
- R5: With falling-edge select at 1, a falling edge captures (timestamp C+2) and a rising edge captures nothing.
- R6: Status bit 13 selects the source. At 1, the pps strobe captures the counter value C of the cycle in which it is high, and external edges are ignored. At 0, the strobe is ignored.
- R7: Status bit 15 (valid) is set by a capture. A status write with bit 15 at 0 clears it and re-arms the unit. Writing a 1 to bit 15 or bit 14 never sets either bit.
- R8: A trigger while valid is 1 sets status bit 14 (error). With overwrite at 0, the stored timestamp is kept.
- R9: With overwrite at 1, a trigger while valid is 1 replaces the timestamp and still sets the error bit.
- R10: Status bits 7:0 count triggers only while count-enable is 1, and any status write clears the count.
- R11: A trigger in the same cycle as a status write that clears valid is treated as a fresh capture. Valid becomes 1, error stays 0, and the count restarts at 1 when count-enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| ext_evt_i | input | 1 | asynchronous external event request |
| pps_i | input | 1 | internal one-cycle pps strobe |
| wr_en_i | input | 1 | register write strobe |
| addr_i | input | 3 | register word address |
| wdata_i | input | 16 | write data |
| rdata_o | output | 16 | read data for addr_i |

## Verification
A software write to the status word and a trigger can land in the same clock. The write clears the valid flag and the count, while the trigger sets the valid flag and advances the count. The bench provokes this by driving the status write (valid at 0) and the pps strobe in the same cycle while a capture is pending. The collision is judged correct when the status reads valid with no error, a count of 1 and a timestamp of that cycle's counter value.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  typedef enum logic [2:0] {
    A_CFG    = 3'd0,
    A_PERIOD = 3'd1,
    A_STATUS = 3'd2,
    A_TS_LO  = 3'd3,
    A_TS_HI  = 3'd4,
    A_CNT_LO = 3'd5,
    A_CNT_HI = 3'd6
  } reg_addr_e;

  localparam int CFG_START = 0;
  localparam int CFG_OVR   = 1;
  localparam int CFG_FALL  = 2;

  localparam int ST_VALID = 15;
  localparam int ST_ERR   = 14;
  localparam int ST_TSEL  = 13;

  typedef struct packed {
    logic fall;
    logic ovr;
    logic start;
  } cfg_t;
endpackage

// File: rtl/evcap_sync_edge.sv
module evcap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;
  logic              lvl;

  assign lvl = sh_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_i};
      prev_q <= lvl;
    end
  end

  assign edge_o = fall_sel_i ? (prev_q & ~lvl) : (~prev_q & lvl);
endmodule

// File: rtl/evcap_timebase.sv
module evcap_timebase #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evcap_capture.sv
module evcap_capture #(
  parameter int CNT_W = 32,
  parameter int SEQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ovr_i,
  input  logic             start_i,
  input  logic             wr_status_i,
  input  logic             w_valid_i,
  input  logic             w_err_i,
  input  logic             w_tsel_i,
  output logic             valid_o,
  output logic             err_o,
  output logic             tsel_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic [CNT_W-1:0] ts_o
);
  logic             valid_q, err_q, tsel_q;
  logic [SEQ_W-1:0] seq_q;
  logic [CNT_W-1:0] ts_q;
  logic             valid_w, err_w;
  logic [SEQ_W-1:0] seq_w;

  // software write acts first; a same-cycle trigger then sees the result
  always_comb begin
    valid_w = valid_q;
    err_w   = err_q;
    seq_w   = seq_q;
    if (wr_status_i) begin
      valid_w = valid_q & w_valid_i;
      err_w   = err_q & w_err_i;
      seq_w   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      tsel_q  <= 1'b0;
      seq_q   <= '0;
      ts_q    <= '0;
    end else begin
      valid_q <= valid_w | trig_i;
      err_q   <= err_w | (trig_i & valid_w);
      seq_q   <= seq_w + SEQ_W'(trig_i & start_i);
      if (wr_status_i) tsel_q <= w_tsel_i;
      if (trig_i && (!valid_w || ovr_i)) ts_q <= cnt_i;
    end
  end

  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign tsel_o  = tsel_q;
  assign seq_o   = seq_q;
  assign ts_o    = ts_q;
endmodule

// File: rtl/evcap_unit.sv
module evcap_unit
  import evcap_pkg::*;
#(
  parameter int CNT_W         = 32,
  parameter int REG_W         = 16,
  parameter int ADDR_W        = 3,
  parameter int SEQ_W         = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int CLK_PERIOD_PS = 8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_evt_i,
  input  logic              pps_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o
);
  localparam int CNT_WORDS = CNT_W / REG_W;
  localparam logic [REG_W-1:0] PERIOD_WORD = REG_W'(CLK_PERIOD_PS);

  cfg_t             cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ts_q;
  logic             ext_edge, trig_evt, wr_status;
  logic             st_valid, st_err, st_tsel;
  logic [SEQ_W-1:0] seq_cnt;
  logic [REG_W-1:0] status_word;
  logic [REG_W-1:0] cnt_word [CNT_WORDS];
  logic [REG_W-1:0] ts_word  [CNT_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (wr_en_i && addr_i == ADDR_W'(A_CFG)) begin
      cfg_q.start <= wdata_i[CFG_START];
      cfg_q.ovr   <= wdata_i[CFG_OVR];
      cfg_q.fall  <= wdata_i[CFG_FALL];
    end
  end

  assign wr_status = wr_en_i && addr_i == ADDR_W'(A_STATUS);

  evcap_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt_q)
  );

  evcap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .async_i   (ext_evt_i),
    .fall_sel_i(cfg_q.fall),
    .edge_o    (ext_edge)
  );

  assign trig_evt = st_tsel ? pps_i : ext_edge;

  evcap_capture #(.CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_evt),
    .cnt_i      (cnt_q),
    .ovr_i      (cfg_q.ovr),
    .start_i    (cfg_q.start),
    .wr_status_i(wr_status),
    .w_valid_i  (wdata_i[ST_VALID]),
    .w_err_i    (wdata_i[ST_ERR]),
    .w_tsel_i   (wdata_i[ST_TSEL]),
    .valid_o    (st_valid),
    .err_o      (st_err),
    .tsel_o     (st_tsel),
    .seq_o      (seq_cnt),
    .ts_o       (ts_q)
  );

  for (genvar g = 0; g < CNT_WORDS; g++) begin : g_words
    assign cnt_word[g] = cnt_q[g*REG_W +: REG_W];
    assign ts_word[g]  = ts_q[g*REG_W +: REG_W];
  end

  always_comb begin
    status_word              = '0;
    status_word[ST_VALID]    = st_valid;
    status_word[ST_ERR]      = st_err;
    status_word[ST_TSEL]     = st_tsel;
    status_word[SEQ_W-1:0]   = seq_cnt;
  end

  always_comb begin
    rdata_o = '0;
    case (reg_addr_e'(addr_i))
      A_CFG:    rdata_o = REG_W'({cfg_q.fall, cfg_q.ovr, cfg_q.start});
      A_PERIOD: rdata_o = PERIOD_WORD;
      A_STATUS: rdata_o = status_word;
      A_TS_LO:  rdata_o = ts_word[0];
      A_TS_HI:  rdata_o = ts_word[CNT_WORDS-1];
      A_CNT_LO: rdata_o = cnt_word[0];
      A_CNT_HI: rdata_o = cnt_word[CNT_WORDS-1];
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evcap_unit_chk.sv
module evcap_unit_chk #(
  parameter int CNT_W = 32,
  parameter int SEQ_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             evt,
  input logic             wr_status,
  input logic             ovr,
  input logic             valid,
  input logic             error,
  input logic [SEQ_W-1:0] seq,
  input logic [CNT_W-1:0] ts,
  input logic [CNT_W-1:0] cnt
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

  // R7
  valid_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid) |-> $past(evt));

  // R8
  missed_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && valid && !wr_status) |=> error);

  // R8
  ts_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && valid && !wr_status && !ovr) |=> $stable(ts));

  // R10
  seq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt && !wr_status) |=> $stable(seq));

  // R10
  seq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_status && !evt) |=> seq == '0);
endmodule

bind evcap_unit evcap_unit_chk #(.CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt      (trig_evt),
  .wr_status(wr_status),
  .ovr      (cfg_q.ovr),
  .valid    (st_valid),
  .error    (st_err),
  .seq      (seq_cnt),
  .ts       (ts_q),
  .cnt      (cnt_q)
);

// File: tb/evcap_unit_bench.sv
module evcap_unit_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 3'd0, 16'hFFFF, 16'h0000},
    '{1'b0, 3'd0, 16'h0000, 16'h0007},
    '{1'b1, 3'd0, 16'h0002, 16'h0000},
    '{1'b0, 3'd0, 16'h0000, 16'h0002},
    '{1'b0, 3'd1, 16'h0000, 16'd8000},
    '{1'b1, 3'd0, 16'h0000, 16'h0000},
    '{1'b1, 3'd2, 16'hE0FF, 16'h0000},
    '{1'b0, 3'd2, 16'h0000, 16'h2000},
    '{1'b1, 3'd2, 16'h0000, 16'h0000},
    '{1'b0, 3'd2, 16'h0000, 16'h0000}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_evt_i = 1'b0;
  logic        pps_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  evcap_unit u_evcap_unit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_evt_i(ext_evt_i),
    .pps_i    (pps_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en_i = 1'b1;
    addr_i  = a;
    wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd32(input logic [2:0] lo, output logic [31:0] v);
    logic [15:0] l, h;
    rd(lo, l);
    rd(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic check_status(input string req, input logic [15:0] exp);
    logic [15:0] s;
    rd(3'd2, s);
    check(req, {16'h0, s}, {16'h0, exp});
  endtask

  task automatic check_ts(input string req, input logic [31:0] exp);
    logic [31:0] t;
    rd32(3'd3, t);
    check(req, t, exp);
  endtask

  // drive ext pin at a negedge; returns counter seen in that cycle
  task automatic ext_set(input logic v, output logic [31:0] c);
    rd32(3'd5, c);
    ext_evt_i = v;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [31:0] c, c2, t;

    tick(3);
    // R1 reset state
    rd(3'd0, d); check("R1 cfg", {16'h0, d}, 32'h0);
    check_status("R1 status", 16'h0000);
    check_ts("R1 ts", 32'h0);
    rd32(3'd5, c); check("R1 cnt", c, 32'h0);
    rst_ni = 1'b1;
    tick(1);

    // R3 R7 register vectors
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].addr, d);
        check($sformatf("R3/R7 vector %0d", i), {16'h0, d}, {16'h0, VEC[i].exp});
      end
    end

    // R2 counter
    rd32(3'd5, c);
    tick(10);
    rd32(3'd5, c2);
    check("R2 step", c2 - c, 32'd10);

    // R4 rising edge capture
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'h0000);
    ext_set(1'b1, c);
    tick(2);
    check_status("R4 latency not yet", 16'h0000);
    tick(1);
    check_status("R4 status", 16'h8001);
    check_ts("R4 ts", c + 32'd2);

    // R7 clear, R4 falling ignored
    wr(3'd2, 16'h0000);
    check_status("R7 cleared", 16'h0000);
    ext_set(1'b0, c);
    tick(5);
    check_status("R4 fall ignored", 16'h0000);
    ext_set(1'b1, c);
    tick(4);
    check_status("R7 rearmed", 16'h8001);
    check_ts("R7 ts", c + 32'd2);

    // R8 missed event, no overwrite
    ext_set(1'b0, c2);
    tick(4);
    ext_set(1'b1, c2);
    tick(4);
    check_status("R8 error", 16'hC002);
    check_ts("R8 ts kept", c + 32'd2);
    wr(3'd2, 16'hC000);
    check_status("R7 write ones no set", 16'hC000);

    // R9 overwrite
    wr(3'd0, 16'h0003);
    wr(3'd2, 16'h0000);
    ext_set(1'b0, c);
    tick(4);
    ext_set(1'b1, c);
    tick(4);
    check_status("R9 first", 16'h8001);
    ext_set(1'b0, c);
    tick(4);
    ext_set(1'b1, c);
    tick(4);
    check_status("R9 error", 16'hC002);
    check_ts("R9 ts replaced", c + 32'd2);

    // R5 falling edge
    wr(3'd0, 16'h0005);
    wr(3'd2, 16'h0000);
    ext_set(1'b0, c);
    tick(4);
    check_status("R5 fall status", 16'h8001);
    check_ts("R5 fall ts", c + 32'd2);
    wr(3'd2, 16'h0000);
    ext_set(1'b1, c2);
    tick(5);
    check_status("R5 rise ignored", 16'h0000);

    // R6 pps source
    wr(3'd2, 16'h2000);
    ext_set(1'b0, c2);
    tick(5);
    ext_set(1'b1, c2);
    tick(5);
    check_status("R6 ext ignored", 16'h2000);
    rd32(3'd5, c);
    pps_i = 1'b1;
    tick(1);
    pps_i = 1'b0;
    tick(1);
    check_status("R6 pps status", 16'hA001);
    check_ts("R6 pps ts", c);

    // R10 count disabled
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h2000);
    rd32(3'd5, c);
    pps_i = 1'b1;
    tick(1);
    pps_i = 1'b0;
    tick(1);
    check_status("R10 no count", 16'hA000);

    // R6 strobe ignored with ext source
    wr(3'd2, 16'h0000);
    pps_i = 1'b1;
    tick(1);
    pps_i = 1'b0;
    tick(2);
    check_status("R6 pps ignored", 16'h0000);
    check_ts("R6 ts unchanged", c);

    // R11 same-cycle write and trigger
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'h2000);
    pps_i = 1'b1;
    tick(1);
    pps_i = 1'b0;
    tick(1);
    check_status("R11 setup", 16'hA001);
    rd32(3'd5, t);
    wr_en_i = 1'b1;
    addr_i  = 3'd2;
    wdata_i = 16'h2000;
    pps_i   = 1'b1;
    tick(1);
    wr_en_i = 1'b0;
    pps_i   = 1'b0;
    tick(1);
    check_status("R11 status", 16'hA001);
    check_ts("R11 ts", t);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule